// File: doc/BRIEF.md
# Command-Response Buffer Register Front-End

This block is the register face of a trusted-module command channel on a single-cycle memory-mapped bus. The bus has a 12-bit byte address, a write strobe, four byte enables, 32-bit write data and combinational read data. A host claims the single locality and arms the device with a command-ready request. It then writes a command into a 1280-byte data buffer and rings a start doorbell. It polls until the doorbell clears, reads the response out of the same buffer and finally sends the device back to idle. Request bits and the start bit clear themselves, so host and device complete a handshake instead of treating the registers as plain storage.

A sequencer tracks five phases. Idle (PH_IDLE) is left for Ready (PH_READY) when a command-ready request is taken. Ready moves to Command Reception (PH_RECEIVE) on the first data-buffer write. Ready or Reception moves to Execution (PH_EXECUTE) on a start write. Execution moves to Completion (PH_COMPLETE) when the stub engine finishes. A go-idle request returns Ready, Reception or Completion to Idle. A command-ready request in Completion moves to Ready.

The stub engine waits a programmable number of cycles and then writes a fixed response into the buffer, one word per cycle. The response carries a valid header: tag 0x8001 followed by the total response length. When the enable input is low, the block looks absent: every read returns all ones and every write is dropped.

Top module: `crbf_front`

Register map, byte offsets:
- 0x000: identity word, read only.
- 0x004: locality control. Bit 0 requests access; bit 1 relinquishes it.
- 0x008: locality status. Bit 0 is granted.
- 0x00C: request. Bit 0 is command-ready; bit 1 is go-idle. Both self-clear.
- 0x010: status. Bit 0 is idle; bits 3:1 hold the phase code.
- 0x014: start. Bit 0.
- 0x018 and 0x01C: command address, high and low word.
- 0x020: command size.
- 0x024 and 0x028: response address, low and high word.
- 0x02C: response size.
- 0x030: latency.
- 0x800 to 0xCFF: data buffer. Buffer byte k sits in lane k mod 4 of the word at 0x800 + 4*(k div 4).

## Requirements
- R1: After reset the status reads idle=1 with phase code 0 (Idle), start reads 0, the request register reads 0 and locality granted reads 0.
- R2: Writing 1 to request bit 0 moves Idle to Ready (phase code 1). One cycle later request bit 0 reads 0 and the status idle bit reads 0.
- R3: The first data-buffer write in Ready moves the phase to Reception (code 2). Data-buffer writes in Idle, Execution or Completion leave the buffer unchanged.
- R4: A start write in Ready or Reception makes start read 1 and the phase Execution (code 3). Start stays 1 for at least the programmed latency, then clears to 0 with the phase at Completion (code 4).
- R5: A start write in Idle or Completion is ignored: start stays 0 and the phase is unchanged.
- R6: The response occupies RESP_BYTES buffer bytes. Byte 0 is 0x80 and byte 1 is 0x01 (tag, big-endian). Bytes 2 to 5 hold RESP_BYTES big-endian. Each later byte k is k XOR 0x5A. Bytes past RESP_BYTES in the last word read 0.
- R7: In Completion the response stays readable. Writing 1 to request bit 1 then returns to Idle with the idle bit reading 1.
- R8: A command-ready request written during Execution stays pending (request bit 0 reads 1) until start clears, and then moves Completion to Ready.
- R9: Writing bit 0 of locality control sets locality granted to 1. Writing bit 1 clears it.
- R10: Command address high and low, command size, response address low and high, and response size read back the values written.
- R11: With the enable input low every read returns 0xFFFFFFFF, the first register included, and writes have no effect.
- R12: A data-buffer write changes only the byte lanes whose byte enable is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_en | input | 1 | Device present; low makes the block look absent |
| addr | input | 12 | Byte address |
| we | input | 1 | Write strobe, one cycle per access |
| be | input | 4 | Byte enables of the write |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr, same cycle |

## Verification
The assertions assume the host leaves one quiet cycle after a request write before writing start. A request is only taken on the edge after its write, so start in that cycle would still see the old phase. Each bench access is a single write or read that spans its own clock cycle, which keeps that cycle free. The assertions also assume the programmed latency is not changed while a command executes. The bench writes the latency register only in Idle.

// File: rtl/crbf_pkg.sv
package crbf_pkg;

    typedef enum logic [2:0] {
        PH_IDLE     = 3'd0,
        PH_READY    = 3'd1,
        PH_RECEIVE  = 3'd2,
        PH_EXECUTE  = 3'd3,
        PH_COMPLETE = 3'd4
    } phase_e;

    localparam logic [11:0] OFS_IDENT    = 12'h000;
    localparam logic [11:0] OFS_LOC_CTRL = 12'h004;
    localparam logic [11:0] OFS_LOC_STS  = 12'h008;
    localparam logic [11:0] OFS_REQUEST  = 12'h00C;
    localparam logic [11:0] OFS_STATUS   = 12'h010;
    localparam logic [11:0] OFS_START    = 12'h014;
    localparam logic [11:0] OFS_CMD_HI   = 12'h018;
    localparam logic [11:0] OFS_CMD_LO   = 12'h01C;
    localparam logic [11:0] OFS_CMD_SIZE = 12'h020;
    localparam logic [11:0] OFS_RSP_LO   = 12'h024;
    localparam logic [11:0] OFS_RSP_HI   = 12'h028;
    localparam logic [11:0] OFS_RSP_SIZE = 12'h02C;
    localparam logic [11:0] OFS_LATENCY  = 12'h030;
    localparam logic [11:0] BUF_BASE     = 12'h800;

    // Byte k of the stub response: big-endian tag, big-endian length, then a pattern.
    function automatic logic [7:0] rsp_byte(input int k, input int total, input logic [15:0] tag);
        logic [31:0] len;
        len = 32'(total);
        if (k >= total)  return 8'h00;
        case (k)
            0:       return tag[15:8];
            1:       return tag[7:0];
            2:       return len[31:24];
            3:       return len[23:16];
            4:       return len[15:8];
            5:       return len[7:0];
            default: return 8'(k) ^ 8'h5A;
        endcase
    endfunction

endpackage

// File: rtl/crbf_data_buf.sv
module crbf_data_buf #(
    parameter int BYTES  = 1280,
    parameter int LANES  = 4,
    localparam int WORDS = BYTES / LANES,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic               clk,
    input  logic               host_we,
    input  logic [IDX_W-1:0]   host_idx,
    input  logic [LANES-1:0]   host_be,
    input  logic [8*LANES-1:0] host_wdata,
    input  logic               eng_we,
    input  logic [IDX_W-1:0]   eng_idx,
    input  logic [8*LANES-1:0] eng_wdata,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic [8*LANES-1:0] rd_data
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [7:0] bank [WORDS];

        always_ff @(posedge clk) begin
            if (eng_we) begin
                bank[eng_idx] <= eng_wdata[8*g +: 8];
            end else if (host_we && host_be[g]) begin
                bank[host_idx] <= host_wdata[8*g +: 8];
            end
        end

        assign rd_data[8*g +: 8] = bank[rd_idx];
    end

endmodule

// File: rtl/crbf_stub_engine.sv
module crbf_stub_engine
    import crbf_pkg::*;
#(
    parameter int          BYTES      = 1280,
    parameter int          RESP_BYTES = 16,
    parameter int          LAT_W      = 16,
    parameter logic [15:0] TAG        = 16'h8001,
    localparam int         LANES      = 4,
    localparam int         IDX_W      = $clog2(BYTES / LANES),
    localparam int         NWORDS     = (RESP_BYTES + LANES - 1) / LANES
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               go,
    input  logic [LAT_W-1:0]   latency,
    output logic               we,
    output logic [IDX_W-1:0]   idx,
    output logic [8*LANES-1:0] wdata,
    output logic               done
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(NWORDS - 1);

    typedef enum logic [1:0] {E_IDLE, E_WAIT, E_WRITE} eng_e;

    eng_e             st_q;
    logic [LAT_W-1:0] cnt_q;
    logic [IDX_W-1:0] widx_q;

    initial begin
        assert (RESP_BYTES >= 6 && RESP_BYTES <= BYTES)
            else $error("response length out of range");
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= E_IDLE;
            cnt_q  <= '0;
            widx_q <= '0;
        end else begin
            unique case (st_q)
                E_IDLE: if (go) begin
                    st_q  <= E_WAIT;
                    cnt_q <= latency;
                end
                E_WAIT: if (cnt_q == '0) begin
                    st_q   <= E_WRITE;
                    widx_q <= '0;
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
                E_WRITE: if (widx_q == LAST) begin
                    st_q <= E_IDLE;
                end else begin
                    widx_q <= widx_q + 1'b1;
                end
                default: st_q <= E_IDLE;
            endcase
        end
    end

    always_comb begin
        we   = (st_q == E_WRITE);
        idx  = widx_q;
        done = (st_q == E_WRITE) && (widx_q == LAST);
        for (int l = 0; l < LANES; l++) begin
            wdata[8*l +: 8] = rsp_byte(int'(widx_q) * LANES + l, RESP_BYTES, TAG);
        end
    end

    // R6: writes never run past the response words
    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == E_WRITE) |-> (widx_q <= LAST));

    // R4: the engine never reports done within the first latency cycle after go
    assert_wait_before_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> !done);

endmodule

// File: rtl/crbf_phase_fsm.sv
module crbf_phase_fsm
    import crbf_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   req_ready_wr,
    input  logic   req_idle_wr,
    input  logic   buf_wr,
    input  logic   start_wr,
    input  logic   eng_done,
    output phase_e phase,
    output logic   start_bit,
    output logic   ready_pend,
    output logic   idle_pend,
    output logic   eng_go,
    output logic   buf_open
);

    phase_e phase_q, phase_d;
    logic   start_q;
    logic   rdy_q, idl_q;
    logic   clr_rdy, clr_idl, go_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
        end else begin
            phase_q <= phase_d;
        end
    end

    // next phase and request consumption
    always_comb begin
        phase_d = phase_q;
        clr_rdy = 1'b0;
        clr_idl = 1'b0;
        go_d    = 1'b0;
        unique case (phase_q)
            PH_IDLE: begin
                if (idl_q) begin
                    clr_idl = 1'b1;
                end else if (rdy_q) begin
                    clr_rdy = 1'b1;
                    phase_d = PH_READY;
                end
            end
            PH_READY, PH_RECEIVE: begin
                if (idl_q) begin
                    clr_idl = 1'b1;
                    phase_d = PH_IDLE;
                end else if (rdy_q) begin
                    clr_rdy = 1'b1;
                end else if (start_wr) begin
                    go_d    = 1'b1;
                    phase_d = PH_EXECUTE;
                end else if (buf_wr) begin
                    phase_d = PH_RECEIVE;
                end
            end
            PH_EXECUTE: begin
                if (eng_done) phase_d = PH_COMPLETE;
            end
            PH_COMPLETE: begin
                if (idl_q) begin
                    clr_idl = 1'b1;
                    phase_d = PH_IDLE;
                end else if (rdy_q) begin
                    clr_rdy = 1'b1;
                    phase_d = PH_READY;
                end
            end
            default: phase_d = PH_IDLE;
        endcase
    end

    // handshake bits
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_q <= 1'b0;
            rdy_q   <= 1'b0;
            idl_q   <= 1'b0;
        end else begin
            if (go_d)          start_q <= 1'b1;
            else if (eng_done) start_q <= 1'b0;
            if (req_ready_wr)  rdy_q <= 1'b1;
            else if (clr_rdy)  rdy_q <= 1'b0;
            if (req_idle_wr)   idl_q <= 1'b1;
            else if (clr_idl)  idl_q <= 1'b0;
        end
    end

    // outputs
    always_comb begin
        phase      = phase_q;
        start_bit  = start_q;
        ready_pend = rdy_q;
        idle_pend  = idl_q;
        eng_go     = go_d;
        buf_open   = (phase_q == PH_READY) || (phase_q == PH_RECEIVE);
    end

    // R5: start only rises out of Ready or Reception
    assert_start_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(start_q) |-> ($past(phase_q) == PH_READY || $past(phase_q) == PH_RECEIVE));

    // R4: start holds until the engine reports completion
    assert_start_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (start_q && !eng_done) |=> start_q);

    // R8: a command-ready request is not consumed during Execution
    assert_ready_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_EXECUTE && rdy_q) |=> rdy_q);

    // R3: Reception is entered only from Ready
    assert_reception_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_RECEIVE && $past(phase_q) != PH_RECEIVE) |-> $past(phase_q) == PH_READY);

endmodule

// File: rtl/crbf_front.sv
module crbf_front
    import crbf_pkg::*;
#(
    parameter int          BUF_BYTES   = 1280,
    parameter int          RESP_BYTES  = 16,
    parameter int          LAT_W       = 16,
    parameter int          DEF_LATENCY = 8,
    parameter logic [15:0] RSP_TAG     = 16'h8001,
    parameter logic [31:0] IDENT       = 32'h0000_A0C1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        dev_en,
    input  logic [11:0] addr,
    input  logic        we,
    input  logic [3:0]  be,
    input  logic [31:0] wdata,
    output logic [31:0] rdata
);

    localparam int IDX_W = $clog2(BUF_BYTES / 4);

    function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nw,
                                          input logic [3:0] en);
        logic [31:0] r;
        for (int b = 0; b < 4; b++) r[8*b +: 8] = en[b] ? nw[8*b +: 8] : old[8*b +: 8];
        return r;
    endfunction

    logic        wr;
    logic        in_buf;
    logic [11:0] buf_off;
    logic [IDX_W-1:0] buf_idx;

    assign wr      = we && dev_en;
    assign buf_off = addr - BUF_BASE;
    assign in_buf  = (addr >= BUF_BASE) && (32'(buf_off) < 32'(BUF_BYTES));
    assign buf_idx = buf_off[IDX_W+1:2];

    logic wr_req, wr_start, wr_loc, wr_buf;
    assign wr_req   = wr && addr == OFS_REQUEST && be[0];
    assign wr_start = wr && addr == OFS_START && be[0] && wdata[0];
    assign wr_loc   = wr && addr == OFS_LOC_CTRL && be[0];
    assign wr_buf   = wr && in_buf;

    phase_e phase;
    logic   start_bit, ready_pend, idle_pend, eng_go, buf_open;
    logic   eng_we, eng_done;
    logic [IDX_W-1:0] eng_idx;
    logic [31:0] eng_wdata, buf_rdata;

    logic [31:0] cmd_hi_q, cmd_lo_q, cmd_size_q, rsp_lo_q, rsp_hi_q, rsp_size_q;
    logic [LAT_W-1:0] lat_q;
    logic        granted_q;

    crbf_phase_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_ready_wr (wr_req && wdata[0]),
        .req_idle_wr  (wr_req && wdata[1]),
        .buf_wr       (wr_buf),
        .start_wr     (wr_start),
        .eng_done     (eng_done),
        .phase        (phase),
        .start_bit    (start_bit),
        .ready_pend   (ready_pend),
        .idle_pend    (idle_pend),
        .eng_go       (eng_go),
        .buf_open     (buf_open)
    );

    crbf_stub_engine #(
        .BYTES      (BUF_BYTES),
        .RESP_BYTES (RESP_BYTES),
        .LAT_W      (LAT_W),
        .TAG        (RSP_TAG)
    ) u_eng (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (eng_go),
        .latency (lat_q),
        .we      (eng_we),
        .idx     (eng_idx),
        .wdata   (eng_wdata),
        .done    (eng_done)
    );

    crbf_data_buf #(
        .BYTES (BUF_BYTES),
        .LANES (4)
    ) u_buf (
        .clk        (clk),
        .host_we    (wr_buf && buf_open),
        .host_idx   (buf_idx),
        .host_be    (be),
        .host_wdata (wdata),
        .eng_we     (eng_we),
        .eng_idx    (eng_idx),
        .eng_wdata  (eng_wdata),
        .rd_idx     (buf_idx),
        .rd_data    (buf_rdata)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_hi_q   <= '0;
            cmd_lo_q   <= '0;
            cmd_size_q <= 32'(BUF_BYTES);
            rsp_lo_q   <= '0;
            rsp_hi_q   <= '0;
            rsp_size_q <= 32'(BUF_BYTES);
            lat_q      <= LAT_W'(DEF_LATENCY);
            granted_q  <= 1'b0;
        end else if (wr) begin
            unique case (addr)
                OFS_CMD_HI:   cmd_hi_q   <= merge(cmd_hi_q, wdata, be);
                OFS_CMD_LO:   cmd_lo_q   <= merge(cmd_lo_q, wdata, be);
                OFS_CMD_SIZE: cmd_size_q <= merge(cmd_size_q, wdata, be);
                OFS_RSP_LO:   rsp_lo_q   <= merge(rsp_lo_q, wdata, be);
                OFS_RSP_HI:   rsp_hi_q   <= merge(rsp_hi_q, wdata, be);
                OFS_RSP_SIZE: rsp_size_q <= merge(rsp_size_q, wdata, be);
                OFS_LATENCY:  lat_q      <= LAT_W'(merge(32'(lat_q), wdata, be));
                OFS_LOC_CTRL: begin
                    if (be[0] && wdata[0])      granted_q <= 1'b1;
                    else if (be[0] && wdata[1]) granted_q <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    logic [31:0] rd;
    always_comb begin
        rd = '0;
        if (in_buf) begin
            rd = buf_rdata;
        end else begin
            case (addr)
                OFS_IDENT:    rd = IDENT;
                OFS_LOC_STS:  rd = {31'd0, granted_q};
                OFS_REQUEST:  rd = {30'd0, idle_pend, ready_pend};
                OFS_STATUS:   rd = {28'd0, phase, phase == PH_IDLE};
                OFS_START:    rd = {31'd0, start_bit};
                OFS_CMD_HI:   rd = cmd_hi_q;
                OFS_CMD_LO:   rd = cmd_lo_q;
                OFS_CMD_SIZE: rd = cmd_size_q;
                OFS_RSP_LO:   rd = rsp_lo_q;
                OFS_RSP_HI:   rd = rsp_hi_q;
                OFS_RSP_SIZE: rd = rsp_size_q;
                OFS_LATENCY:  rd = 32'(lat_q);
                default:      rd = '0;
            endcase
        end
        rdata = dev_en ? rd : '1;
    end

    // R9: granted only rises after a locality request write
    assert_grant_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(granted_q) |-> $past(wr_loc && wdata[0]));

    // R11: nothing changes state while the device is disabled
    assert_disabled_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!dev_en && !start_bit) |=> $stable(granted_q));

endmodule

// File: tb/sim_crbf_front.sv
module sim_crbf_front;
    import crbf_pkg::*;

    localparam int RESP = 16;
    localparam int LAT  = 20;
    localparam int NW   = (RESP + 3) / 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dev_en = 1'b1;
    logic [11:0] addr = '0;
    logic        we = 1'b0;
    logic [3:0]  be = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    crbf_front #(.RESP_BYTES(RESP)) u0 (
        .clk(clk), .rst_n(rst_n), .dev_en(dev_en), .addr(addr),
        .we(we), .be(be), .wdata(wdata), .rdata(rdata)
    );

    task automatic check(input string req, input string what, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%08h expected=%08h", req, what, act, exp);
        end
    endtask

    task automatic wr32(input logic [11:0] a, input logic [31:0] d, input logic [3:0] e = 4'hF);
        @(negedge clk);
        addr = a; wdata = d; be = e; we = 1'b1;
        @(negedge clk);
        we = 1'b0; be = '0;
    endtask

    task automatic rd32(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        @(posedge clk);
        #1 d = rdata;
    endtask

    function automatic logic [7:0] exp_byte(input int k);
        if (k >= RESP) return 8'h00;
        if (k == 0) return 8'h80;
        if (k == 1) return 8'h01;
        if (k >= 2 && k <= 5) return 8'(32'(RESP) >> (8 * (5 - k)));
        return 8'(k) ^ 8'h5A;
    endfunction

    function automatic logic [31:0] exp_word(input int w);
        return {exp_byte(4*w+3), exp_byte(4*w+2), exp_byte(4*w+1), exp_byte(4*w)};
    endfunction

    // status word: bit0 idle, bits 3:1 phase code
    function automatic logic [31:0] sts(input int ph);
        return {28'd0, 3'(ph), ph == 0};
    endfunction

    task automatic t_reset;
        logic [31:0] d;
        rd32(OFS_STATUS, d);  check("R1", "status after reset", d, sts(0));
        rd32(OFS_START, d);   check("R1", "start after reset", d, 0);
        rd32(OFS_REQUEST, d); check("R1", "request after reset", d, 0);
        rd32(OFS_LOC_STS, d); check("R1", "granted after reset", d, 0);
    endtask

    task automatic t_locality;
        logic [31:0] d;
        wr32(OFS_LOC_CTRL, 32'h1);
        rd32(OFS_LOC_STS, d); check("R9", "granted after request", d, 1);
        wr32(OFS_LOC_CTRL, 32'h2);
        rd32(OFS_LOC_STS, d); check("R9", "granted after relinquish", d, 0);
        wr32(OFS_LOC_CTRL, 32'h1);
        rd32(OFS_LOC_STS, d); check("R9", "granted again", d, 1);
    endtask

    task automatic t_regs;
        logic [31:0] d;
        wr32(OFS_CMD_HI, 32'h0000_0001);
        wr32(OFS_CMD_LO, 32'hFED4_0080);
        wr32(OFS_CMD_SIZE, 32'h0000_0500);
        wr32(OFS_RSP_LO, 32'hFED4_0080);
        wr32(OFS_RSP_HI, 32'h0000_0002);
        wr32(OFS_RSP_SIZE, 32'h0000_04FF);
        rd32(OFS_CMD_HI, d);   check("R10", "command address high", d, 32'h0000_0001);
        rd32(OFS_CMD_LO, d);   check("R10", "command address low", d, 32'hFED4_0080);
        rd32(OFS_CMD_SIZE, d); check("R10", "command size", d, 32'h0000_0500);
        rd32(OFS_RSP_LO, d);   check("R10", "response address low", d, 32'hFED4_0080);
        rd32(OFS_RSP_HI, d);   check("R10", "response address high", d, 32'h0000_0002);
        rd32(OFS_RSP_SIZE, d); check("R10", "response size", d, 32'h0000_04FF);
    endtask

    task automatic wait_start_clear(output int polls);
        logic [31:0] d;
        polls = 0;
        d = 1;
        while (d[0] && polls < 1000) begin
            rd32(OFS_START, d);
            polls++;
        end
    endtask

    task automatic t_command;
        logic [31:0] d;
        int polls;
        wr32(OFS_LATENCY, LAT);
        wr32(OFS_REQUEST, 32'h1);
        rd32(OFS_REQUEST, d); check("R2", "cmd-ready self-cleared", d, 0);
        rd32(OFS_STATUS, d);  check("R2", "status in Ready", d, sts(1));
        wr32(BUF_BASE + 12'h008, 32'h1122_3344);
        rd32(OFS_STATUS, d);  check("R3", "status in Reception", d, sts(2));
        rd32(BUF_BASE + 12'h008, d); check("R3", "command word stored", d, 32'h1122_3344);
        wr32(BUF_BASE + 12'h008, 32'hAABB_CCDD, 4'b0101);
        rd32(BUF_BASE + 12'h008, d); check("R12", "partial byte write", d, 32'h11BB_33DD);
        wr32(OFS_START, 32'h1);
        rd32(OFS_START, d);   check("R4", "start set", d, 1);
        rd32(OFS_STATUS, d);  check("R4", "status in Execution", d, sts(3));
        wr32(BUF_BASE, 32'hDEAD_BEEF);
        wait_start_clear(polls);
        check("R4", "start cleared after latency", (polls >= LAT && polls <= LAT + NW + 4), 1);
        rd32(OFS_STATUS, d);  check("R4", "status in Completion", d, sts(4));
        for (int w = 0; w < NW; w++) begin
            rd32(BUF_BASE + 12'(4 * w), d);
            check("R6", $sformatf("response word %0d", w), d, exp_word(w));
        end
        wr32(OFS_START, 32'h1);
        rd32(OFS_START, d);   check("R5", "start ignored in Completion", d, 0);
        rd32(OFS_STATUS, d);  check("R5", "phase kept in Completion", d, sts(4));
        wr32(BUF_BASE, 32'hCAFE_F00D);
        rd32(BUF_BASE, d);    check("R3", "buffer write ignored in Completion", d, exp_word(0));
        rd32(BUF_BASE + 12'h004, d); check("R7", "response readable in Completion", d, exp_word(1));
        wr32(OFS_REQUEST, 32'h2);
        rd32(OFS_STATUS, d);  check("R7", "status after go-idle", d, sts(0));
        rd32(OFS_REQUEST, d); check("R7", "go-idle self-cleared", d, 0);
        wr32(BUF_BASE, 32'h1234_5678);
        rd32(BUF_BASE, d);    check("R3", "buffer write ignored in Idle", d, exp_word(0));
        wr32(OFS_START, 32'h1);
        rd32(OFS_START, d);   check("R5", "start ignored in Idle", d, 0);
        rd32(OFS_STATUS, d);  check("R5", "phase kept in Idle", d, sts(0));
    endtask

    task automatic t_ready_in_exec;
        logic [31:0] d;
        int polls;
        wr32(OFS_REQUEST, 32'h1);
        rd32(OFS_STATUS, d);  check("R8", "Ready before start", d, sts(1));
        wr32(OFS_START, 32'h1);
        wr32(OFS_REQUEST, 32'h1);
        rd32(OFS_REQUEST, d); check("R8", "cmd-ready pending in Execution", d, 1);
        rd32(OFS_STATUS, d);  check("R8", "still Execution", d, sts(3));
        wait_start_clear(polls);
        rd32(OFS_STATUS, d);  check("R8", "Ready after completion", d, sts(1));
        rd32(OFS_REQUEST, d); check("R8", "cmd-ready consumed", d, 0);
        wr32(OFS_REQUEST, 32'h2);
        rd32(OFS_STATUS, d);  check("R7", "back to Idle", d, sts(0));
    endtask

    task automatic t_disabled;
        logic [31:0] d;
        rd32(OFS_IDENT, d);   check("R11", "ident while enabled", (d[7:0] != 8'hFF), 1);
        dev_en = 1'b0;
        rd32(OFS_IDENT, d);   check("R11", "ident while disabled", d, 32'hFFFF_FFFF);
        rd32(OFS_STATUS, d);  check("R11", "status while disabled", d, 32'hFFFF_FFFF);
        wr32(OFS_LOC_CTRL, 32'h2);
        wr32(OFS_CMD_HI, 32'h5555_AAAA);
        wr32(OFS_REQUEST, 32'h1);
        dev_en = 1'b1;
        rd32(OFS_LOC_STS, d); check("R11", "granted unchanged", d, 1);
        rd32(OFS_CMD_HI, d);  check("R11", "register unchanged", d, 32'h0000_0001);
        rd32(OFS_STATUS, d);  check("R11", "phase unchanged", d, sts(0));
    endtask

    initial begin
        #20000000;
        errors++;
        $display("FAIL watchdog all requirements actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        t_reset();
        t_locality();
        t_regs();
        t_command();
        t_ready_in_exec();
        t_disabled();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule